// File: doc/BRIEF.md
# PCI Configuration Enumeration Sequencer

This block locates one single-function target on a PCI segment with no bridge between host and target, and then prepares that target for I/O access. It does this entirely in hardware. It has a request/response port for configuration accesses, and a separate bus-cycle engine (not part of this block) turns each access into real bus cycles. The sequencer only builds type 0 configuration addresses, issues the accesses one at a time and decides what to do with each answer.

When `start` is pulsed, the block captures a target identifier and an I/O base address. It then reads configuration register 0 through each device-select line in turn. On the first line whose read value equals the identifier, it records that line's bit number. It then turns on I/O decoding through the command register and writes the base address into the first base address register. If no line answers with the identifier, it finishes without writing anything. Completion is a one-cycle `done` pulse. The `found` flag and `match_line` stay valid until the next start or a reset.

Top module: `cfg_enum_seq`

## Requirements
- R1: Every access address has bits 1:0 equal to 00, the register number in bits 7:2 and the function number 000 in bits 10:8.
- R2: Every access address has exactly one bit set among bits 31:11. That bit is the device-select line being addressed.
- R3: Reads go to register 0 and visit select lines 11, 12, ... 31 in ascending order, one read per line. Scanning stops at the first matching line.
- R4: A line matches only when its read value equals the captured target identifier and is non-zero. A zero read value never matches, even when the identifier is zero.
- R5: On a match, `found` becomes 1 and `match_line` holds the bit number of the matching select line. Both hold until the next accepted start or reset.
- R6: After a match, the block issues exactly two writes, both addressed at the matching line. The first writes 0x00000001 to register 1 (command). The second writes the captured I/O base to register 4 (first base address register).
- R7: If none of the 21 lines matches, the block makes 21 reads and no writes, and ends with `found` = 0.
- R8: Only one access is outstanding at a time. `acc_req` is a one-cycle pulse, and the next pulse waits until `acc_done` has been seen for the current access. `acc_rdata` is sampled in the cycle where `acc_done` is 1.
- R9: `busy` is 1 from the cycle after an accepted start through the `done` cycle. `done` is a single-cycle pulse, and `busy` is 0 in the cycle after it.
- R10: A synchronous active-high `rst` returns the block to idle with `busy`, `done`, `found`, `acc_req` and `match_line` all 0, including in the middle of a scan.
- R11: `start` while `busy` is ignored. The identifier and base captured at the accepted start stay in use, and the scan does not restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin enumeration; accepted only when idle |
| target_id | input | 32 | Device/vendor identifier to look for, captured on start |
| io_base | input | 32 | I/O base address to program, captured on start |
| acc_req | output | 1 | One-cycle pulse launching a configuration access |
| acc_addr | output | 32 | Type 0 configuration address |
| acc_write | output | 1 | 1 for a write access, 0 for a read |
| acc_wdata | output | 32 | Write data |
| acc_done | input | 1 | Access completion pulse from the bus-cycle engine |
| acc_rdata | input | 32 | Read data, valid with acc_done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Target was found and programmed |
| match_line | output | 5 | Bit number of the matching select line |

## Verification
The scan runs with the target placed on the first line (11), a middle line (20) and the last line (31). These cases separate an off-by-one in the line counter from a wrong stop condition, because the number of reads must equal the line number minus ten. One target carries a mismatching identifier and another case uses an all-zero identifier with no device present. Both must end as not-found after 21 reads and no writes, which separates the equality test from a bare non-zero test. Response latencies of one to three cycles show that each step waits for completion instead of counting a fixed delay. Directed runs cover a start pulse during a scan and a reset in the middle of a scan.

// File: rtl/cfg_enum_pkg.sv
package cfg_enum_pkg;

    localparam int CFG_DW     = 32;
    localparam int LINE_W     = 5;
    localparam int REGNO_W    = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_CMD_REQ,
        ST_CMD_WAIT,
        ST_BAR_REQ,
        ST_BAR_WAIT,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic [CFG_DW-1:0] addr;
        logic              write;
        logic [CFG_DW-1:0] wdata;
    } cfg_access_t;

    // Type 0 address: one select bit, function number, register number, 00.
    function automatic logic [CFG_DW-1:0] type0_addr(
        input logic [LINE_W-1:0]  line,
        input logic [2:0]         func,
        input logic [REGNO_W-1:0] regno
    );
        logic [CFG_DW-1:0] a;
        a        = '0;
        a[line]  = 1'b1;
        a[10:8]  = func;
        a[7:2]   = regno;
        a[1:0]   = 2'b00;
        return a;
    endfunction

endpackage

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
    import cfg_enum_pkg::*;
#(
    parameter int FUNC_NUM = 0
) (
    input  logic [LINE_W-1:0]  line,
    input  logic [REGNO_W-1:0] regno,
    output logic [CFG_DW-1:0]  addr
);
    localparam logic [2:0] FUNC_L = 3'(FUNC_NUM);

    always_comb begin
        addr = type0_addr(line, FUNC_L, regno);
    end
endmodule

// File: rtl/cfg_line_ctr.sv
module cfg_line_ctr
    import cfg_enum_pkg::*;
#(
    parameter int FIRST_LINE = 11,
    parameter int LAST_LINE  = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    output logic [LINE_W-1:0] line,
    output logic              at_last
);
    localparam logic [LINE_W-1:0] FIRST_L = LINE_W'(FIRST_LINE);
    localparam logic [LINE_W-1:0] LAST_L  = LINE_W'(LAST_LINE);

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= FIRST_L;
        end else if (load) begin
            line <= FIRST_L;
        end else if (adv && (line != LAST_L)) begin
            line <= line + 1'b1;
        end
    end

    assign at_last = (line == LAST_L);
endmodule

// File: rtl/cfg_enum_seq.sv
module cfg_enum_seq
    import cfg_enum_pkg::*;
#(
    parameter int          FIRST_LINE = 11,
    parameter int          LAST_LINE  = 31,
    parameter int          FUNC_NUM   = 0,
    parameter int          ID_REG     = 0,
    parameter int          CMD_REG    = 1,
    parameter int          BAR_REG    = 4,
    parameter logic [31:0] CMD_ENABLE = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] target_id,
    input  logic [31:0] io_base,
    output logic        acc_req,
    output logic [31:0] acc_addr,
    output logic        acc_write,
    output logic [31:0] acc_wdata,
    input  logic        acc_done,
    input  logic [31:0] acc_rdata,
    output logic        busy,
    output logic        done,
    output logic        found,
    output logic [4:0]  match_line
);
    localparam logic [REGNO_W-1:0] ID_REG_L  = REGNO_W'(ID_REG);
    localparam logic [REGNO_W-1:0] CMD_REG_L = REGNO_W'(CMD_REG);
    localparam logic [REGNO_W-1:0] BAR_REG_L = REGNO_W'(BAR_REG);

    seq_state_e          state_q, state_d;
    logic [CFG_DW-1:0]   tgt_q, base_q;
    logic                found_q;
    logic [LINE_W-1:0]   match_q;
    logic [LINE_W-1:0]   scan_line;
    logic                scan_last;
    logic                accept, hit, scan_adv;
    logic [LINE_W-1:0]   sel_line;
    logic [REGNO_W-1:0]  sel_reg;
    cfg_access_t         acc;

    assign accept   = (state_q == ST_IDLE) && start;
    assign hit      = (acc_rdata == tgt_q) && (acc_rdata != '0);
    assign scan_adv = (state_q == ST_RD_WAIT) && acc_done && !hit;

    cfg_line_ctr #(
        .FIRST_LINE (FIRST_LINE),
        .LAST_LINE  (LAST_LINE)
    ) i_line_ctr (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .adv     (scan_adv),
        .line    (scan_line),
        .at_last (scan_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_RD_REQ;
            ST_RD_REQ:   state_d = ST_RD_WAIT;
            ST_RD_WAIT:  if (acc_done) begin
                             if (hit)            state_d = ST_CMD_REQ;
                             else if (scan_last) state_d = ST_FINISH;
                             else                state_d = ST_RD_REQ;
                         end
            ST_CMD_REQ:  state_d = ST_CMD_WAIT;
            ST_CMD_WAIT: if (acc_done) state_d = ST_BAR_REQ;
            ST_BAR_REQ:  state_d = ST_BAR_WAIT;
            ST_BAR_WAIT: if (acc_done) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
            base_q  <= '0;
            found_q <= 1'b0;
            match_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                tgt_q   <= target_id;
                base_q  <= io_base;
                found_q <= 1'b0;
                match_q <= '0;
            end else if ((state_q == ST_RD_WAIT) && acc_done && hit) begin
                found_q <= 1'b1;
                match_q <= scan_line;
            end
        end
    end

    // Access selection: which line and register the current step targets
    always_comb begin
        sel_line = scan_line;
        sel_reg  = ID_REG_L;
        unique case (state_q)
            ST_CMD_REQ, ST_CMD_WAIT: begin
                sel_line = match_q;
                sel_reg  = CMD_REG_L;
            end
            ST_BAR_REQ, ST_BAR_WAIT: begin
                sel_line = match_q;
                sel_reg  = BAR_REG_L;
            end
            default: begin
                sel_line = scan_line;
                sel_reg  = ID_REG_L;
            end
        endcase
    end

    cfg_addr_gen #(
        .FUNC_NUM (FUNC_NUM)
    ) i_addr_gen (
        .line  (sel_line),
        .regno (sel_reg),
        .addr  (acc.addr)
    );

    always_comb begin
        acc.write = (state_q == ST_CMD_REQ) || (state_q == ST_CMD_WAIT) ||
                    (state_q == ST_BAR_REQ) || (state_q == ST_BAR_WAIT);
        if ((state_q == ST_CMD_REQ) || (state_q == ST_CMD_WAIT))
            acc.wdata = CMD_ENABLE;
        else if ((state_q == ST_BAR_REQ) || (state_q == ST_BAR_WAIT))
            acc.wdata = base_q;
        else
            acc.wdata = '0;
    end

    assign acc_req    = (state_q == ST_RD_REQ) || (state_q == ST_CMD_REQ) ||
                        (state_q == ST_BAR_REQ);
    assign acc_addr   = acc.addr;
    assign acc_write  = acc.write;
    assign acc_wdata  = acc.wdata;
    assign busy       = (state_q != ST_IDLE);
    assign done       = (state_q == ST_FINISH);
    assign found      = found_q;
    assign match_line = match_q;

endmodule

// File: rtl/cfg_enum_seq_chk.sv
module cfg_enum_seq_chk #(
    parameter int FIRST_LINE = 11,
    parameter int LAST_LINE  = 31
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        acc_req,
    input logic [31:0] acc_addr,
    input logic        acc_write,
    input logic        acc_done,
    input logic        busy,
    input logic        done,
    input logic        found,
    input logic [4:0]  match_line
);
    logic outst;

    always_ff @(posedge clk) begin
        if (rst)           outst <= 1'b0;
        else if (acc_req)  outst <= 1'b1;
        else if (acc_done) outst <= 1'b0;
    end

    p_addr_low_r1: assert property (@(posedge clk) disable iff (rst)
        acc_req |-> (acc_addr[1:0] == 2'b00) && (acc_addr[10:8] == 3'b000));

    p_one_select_r2: assert property (@(posedge clk) disable iff (rst)
        acc_req |-> ($countones(acc_addr[31:11]) == 1));

    p_read_id_reg_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_req && !acc_write) |-> (acc_addr[7:2] == 6'd0));

    p_line_range_r5: assert property (@(posedge clk) disable iff (rst)
        found |-> (int'(match_line) >= FIRST_LINE) && (int'(match_line) <= LAST_LINE));

    p_write_after_match_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_write) |-> found);

    p_single_outstanding_r8: assert property (@(posedge clk) disable iff (rst)
        (outst && !acc_done) |-> !acc_req);

    p_req_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        acc_req |=> !acc_req);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> (!busy && !done && !found && !acc_req));

    p_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> busy);

endmodule

bind cfg_enum_seq cfg_enum_seq_chk #(
    .FIRST_LINE (FIRST_LINE),
    .LAST_LINE  (LAST_LINE)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .acc_req    (acc_req),
    .acc_addr   (acc_addr),
    .acc_write  (acc_write),
    .acc_done   (acc_done),
    .busy       (busy),
    .done       (done),
    .found      (found),
    .match_line (match_line)
);

// File: tb/test_cfg_enum_seq.sv
module test_cfg_enum_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] target_id = '0;
    logic [31:0] io_base = '0;
    logic        acc_req;
    logic [31:0] acc_addr;
    logic        acc_write;
    logic [31:0] acc_wdata;
    logic        acc_done;
    logic [31:0] acc_rdata;
    logic        busy, done, found;
    logic [4:0]  match_line;

    int checks = 0;
    int errors = 0;

    // responder model state
    int          dev_line = 0;
    logic [31:0] dev_id = '0;
    int          lat = 1;
    int          rd_cnt, wr_cnt, bad_fmt;
    logic [5:0]  wr_reg  [2];
    logic [31:0] wr_data [2];
    int          wr_line [2];

    always #2 clk = ~clk;

    cfg_enum_seq i_cfg_enum_seq (
        .clk(clk), .rst(rst), .start(start), .target_id(target_id), .io_base(io_base),
        .acc_req(acc_req), .acc_addr(acc_addr), .acc_write(acc_write), .acc_wdata(acc_wdata),
        .acc_done(acc_done), .acc_rdata(acc_rdata), .busy(busy), .done(done),
        .found(found), .match_line(match_line)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Bus-cycle engine model: answers each request after lat cycles
    initial begin
        int cnt;
        logic [31:0] resp;
        cnt = 0; resp = '0;
        acc_done = 1'b0; acc_rdata = '0;
        forever begin
            @(negedge clk);
            acc_done = 1'b0;
            if (rst) begin
                cnt = 0;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    acc_done  = 1'b1;
                    acc_rdata = resp;
                end
            end else if (acc_req) begin
                int sel_cnt, sel;
                sel_cnt = 0; sel = -1;
                for (int b = 11; b < 32; b++) if (acc_addr[b]) begin sel_cnt++; sel = b; end
                if (sel_cnt != 1 || acc_addr[1:0] != 2'b00 || acc_addr[10:8] != 3'b000) bad_fmt++;
                if (!acc_write) begin
                    if (acc_addr[7:2] != 6'd0) bad_fmt++;
                    if (sel != 11 + rd_cnt) bad_fmt++;
                    rd_cnt++;
                    resp = (sel == dev_line) ? dev_id : 32'h0;
                end else begin
                    if (wr_cnt < 2) begin
                        wr_reg[wr_cnt]  = acc_addr[7:2];
                        wr_data[wr_cnt] = acc_wdata;
                        wr_line[wr_cnt] = sel;
                    end
                    wr_cnt++;
                    resp = '0;
                end
                cnt = lat;
            end
        end
    end

    task automatic launch(input logic [31:0] tgt, input logic [31:0] base);
        @(negedge clk);
        target_id = tgt; io_base = base; start = 1'b1;
        rd_cnt = 0; wr_cnt = 0; bad_fmt = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic check_result(input logic exp_found, input int exp_line, input logic [31:0] base);
        chk(found == exp_found, "R4/R5/R7 found", found, exp_found);
        chk(bad_fmt == 0, "R1/R2/R3 address format and order", bad_fmt, 0);
        chk(rd_cnt == (exp_found ? exp_line - 10 : 21), "R3/R7 read count",
            rd_cnt, exp_found ? exp_line - 10 : 21);
        if (exp_found) begin
            chk(int'(match_line) == exp_line, "R5 match_line", match_line, exp_line);
            chk(wr_cnt == 2, "R6 write count", wr_cnt, 2);
            chk(wr_reg[0] == 6'd1 && wr_data[0] == 32'h1, "R6 command write",
                {wr_reg[0], wr_data[0]}, {6'd1, 32'h1});
            chk(wr_reg[1] == 6'd4 && wr_data[1] == base, "R6 base write",
                {wr_reg[1], wr_data[1]}, {6'd4, base});
            chk(wr_line[0] == exp_line && wr_line[1] == exp_line, "R6 write line",
                wr_line[1], exp_line);
        end else begin
            chk(wr_cnt == 0, "R7 no writes", wr_cnt, 0);
        end
    endtask

    typedef struct packed {
        logic [4:0]  dline;
        logic [31:0] did;
        logic [31:0] tgt;
        logic [31:0] base;
        logic [1:0]  lt;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{5'd20, 32'h8029_10EC, 32'h8029_10EC, 32'h0000_E400, 2'd1},
        '{5'd11, 32'h1234_5678, 32'h1234_5678, 32'h0000_0100, 2'd3},
        '{5'd31, 32'h8029_10EC, 32'h8029_10EC, 32'h0000_FC00, 2'd2},
        '{5'd15, 32'h1111_2222, 32'h8029_10EC, 32'h0000_E400, 2'd1},
        '{5'd0,  32'h0000_0000, 32'h0000_0000, 32'h0000_E400, 2'd2}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !found && !acc_req && match_line == 0, "R10 reset state",
            {busy, done, found, acc_req, match_line}, 0);

        for (int i = 0; i < 5; i++) begin
            logic ef;
            dev_line = int'(VECS[i].dline);
            dev_id   = VECS[i].did;
            lat      = int'(VECS[i].lt);
            ef = (VECS[i].dline != 0) && (VECS[i].did == VECS[i].tgt) && (VECS[i].tgt != 0);
            launch(VECS[i].tgt, VECS[i].base);
            chk(busy == 1'b1, "R9 busy after start", busy, 1);
            wait_done();
            check_result(ef, int'(VECS[i].dline), VECS[i].base);
            @(negedge clk);
            chk(!done && !busy, "R9 done pulse", {done, busy}, 0);
        end

        // R11: start during a scan is ignored
        dev_line = 25; dev_id = 32'hCAFE_0001; lat = 1;
        launch(32'hCAFE_0001, 32'h0000_2000);
        repeat (4) @(negedge clk);
        target_id = 32'hDEAD_BEEF; io_base = 32'h0000_1234; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_result(1'b1, 25, 32'h0000_2000);
        chk(rd_cnt == 15, "R11 scan not restarted", rd_cnt, 15);
        @(negedge clk);
        chk(found && match_line == 5'd25, "R5 status held after done", match_line, 25);

        // R10 reset clears status
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!found && match_line == 0 && !busy, "R10 reset clears status",
            {found, match_line, busy}, 0);

        // R10 reset in the middle of a scan
        dev_line = 0; lat = 2;
        launch(32'h8029_10EC, 32'h0000_E400);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !acc_req && !done, "R10 mid-scan reset", {busy, acc_req, done}, 0);
        @(negedge clk);
        dev_line = 18; dev_id = 32'h8029_10EC; lat = 1;
        launch(32'h8029_10EC, 32'h0000_E400);
        wait_done();
        check_result(1'b1, 18, 32'h0000_E400);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule